// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Flag

This block compares a reference pulse train with the output of a feedback divider and issues a three-state command for a charge pump. The command is "push up", "push down" or "float". Both pulse inputs are sampled on the oscillator clock. A rising edge on either input opens a comparison. The edge on the other input closes it.

While a comparison is open, one drive output is held for as many clock cycles as the two edges are apart. A polarity input selects which drive output that is, so the same block can serve a VCO of either tuning slope. If the same input shows a second edge before the other input answers, the pending drive simply continues. This gives phase-frequency detector behaviour over a range of plus or minus one full cycle.

A lock detector measures each comparison's error in oscillator cycles. It raises its flag only after a run of three consecutive comparisons whose error is below a 12-cycle window. It drops the flag as soon as any error reaches the window. A power-save input parks the comparator: both drives go inactive, the flag reads locked, and edges are ignored. When the input returns high, a one-cycle request tells the surrounding dividers to restart in phase.

Top module: `pfd_lock_top`

## Requirements
- R1: With `polarity` high and a `refIn` rising edge sampled k clock cycles before a `divIn` rising edge (k ≥ 1), `driveUp` is high for exactly k cycles, starting in the cycle after the `refIn` edge is sampled, and `driveDown` stays low.
- R2: With `polarity` high and the `divIn` edge first by k cycles, `driveDown` is high for exactly k cycles and `driveUp` stays low.
- R3: With `polarity` low, the roles of `driveUp` and `driveDown` in R1 and R2 are exchanged.
- R4: Rising edges on `refIn` and `divIn` sampled in the same cycle leave both drives low (high-impedance command).
- R5: `driveUp` and `driveDown` are never high in the same cycle.
- R6: A second `refIn` edge that arrives while an earlier one is still waiting for its `divIn` edge does not end or restart the pending pulse. The drive stays high until the `divIn` edge.
- R7: A comparison's error is the number of cycles its drive output was high; an error below 12 counts as good. `locked` rises in the cycle after the edge that closes the third consecutive good comparison, and it stays high through further good ones.
- R8: Once a drive output has been held for 12 consecutive cycles, `locked` is low from the 13th cycle on, even if the closing edge has not yet arrived.
- R9: A comparison with an error of 12 or more clears the run of good comparisons, so three new good ones are needed to raise `locked` again.
- R10: While `powerOn` is low, both drive outputs are low, `locked` reads high, and input edges open no comparison.
- R11: When `powerOn` rises, `alignReq` is high for exactly one cycle, starting in the cycle after the rise is sampled. After the return, `locked` is low and any pulse that was pending is gone.
- R12: After reset, both drives are low, `locked` is low if `powerOn` is high and high if `powerOn` is low, and `alignReq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all sampling and counting use it |
| rstN | input | 1 | Asynchronous active-low reset |
| powerOn | input | 1 | High = operating, low = standby |
| polarity | input | 1 | High = reference-leads gives up-drive; low = swapped |
| refIn | input | 1 | Reference pulse train |
| divIn | input | 1 | Divided feedback pulse train |
| driveUp | output | 1 | Charge-pump source enable |
| driveDown | output | 1 | Charge-pump sink enable |
| locked | output | 1 | Lock flag |
| alignReq | output | 1 | One-cycle request to phase-reset both dividers |

## Verification
The checker watches every cycle for conflicting drives, for the parked state during standby, and for a lock rise that follows anything other than a closing edge. It also checks that the realignment request is a single cycle, issued right after each return from standby. The exact pulse widths, the three-comparison lock count, the early unlock on a long pending pulse, and the swap under polarity can only be shown by the bench. It does this with edge pairs at chosen and random spacings, and it compares each drive's high-cycle count and each lock transition with values predicted from the requirements.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  // Strobes from the edge/flag control into the error datapath.
  typedef struct packed {
    logic run;   // comparator active (not in standby)
    logic busy;  // a drive pulse is pending this cycle
    logic done;  // the closing edge of a comparison is sampled now
  } cmpStrobe_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerOn,
  input  logic       refIn,
  input  logic       divIn,
  output logic       leadRef,
  output logic       leadDiv,
  output logic       alignReq,
  output cmpStrobe_t st
);
  logic refPrev, divPrev, powerPrev;
  logic refEdge, divEdge;
  logic upNext, dnNext, bothSet;

  assign refEdge = powerOn & refIn & ~refPrev;
  assign divEdge = powerOn & divIn & ~divPrev;
  assign upNext  = leadRef | refEdge;
  assign dnNext  = leadDiv | divEdge;
  assign bothSet = upNext & dnNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev   <= 1'b0;
      divPrev   <= 1'b0;
      powerPrev <= 1'b0;
      alignReq  <= 1'b0;
      leadRef   <= 1'b0;
      leadDiv   <= 1'b0;
    end else begin
      refPrev   <= refIn;
      divPrev   <= divIn;
      powerPrev <= powerOn;
      alignReq  <= powerOn & ~powerPrev;
      if (!powerOn) begin
        leadRef <= 1'b0;
        leadDiv <= 1'b0;
      end else begin
        // each edge sets its own flag; two set flags clear each other
        leadRef <= upNext & ~bothSet;
        leadDiv <= dnNext & ~bothSet;
      end
    end
  end

  always_comb begin
    st.run  = powerOn;
    st.busy = leadRef | leadDiv;
    st.done = powerOn & bothSet;
  end
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_lock_pkg::*;
#(
  parameter int WINDOW    = 12,
  parameter int GOOD_RUNS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobe_t st,
  output logic       lockReg
);
  localparam int CNT_W  = $clog2(WINDOW + 1);
  localparam int GOOD_W = $clog2(GOOD_RUNS + 1);
  localparam logic [CNT_W:0]    WIN_L  = (CNT_W + 1)'(WINDOW);
  localparam logic [CNT_W-1:0]  WIN_S  = CNT_W'(WINDOW);
  localparam logic [GOOD_W:0]   GOOD_L = (GOOD_W + 1)'(GOOD_RUNS);

  logic [CNT_W-1:0]  errCnt;
  logic [CNT_W:0]    errSum;
  logic [GOOD_W-1:0] goodCnt;
  logic [GOOD_W:0]   goodSum;
  logic              overWin;

  assign errSum  = {1'b0, errCnt} + (CNT_W + 1)'(st.busy);
  assign overWin = (errSum >= WIN_L);
  assign goodSum = {1'b0, goodCnt} + (GOOD_W + 1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt  <= '0;
      goodCnt <= '0;
      lockReg <= 1'b0;
    end else if (!st.run) begin
      errCnt  <= '0;
      goodCnt <= '0;
      lockReg <= 1'b0;
    end else if (st.done) begin
      errCnt <= '0;
      if (overWin) begin
        goodCnt <= '0;
        lockReg <= 1'b0;
      end else begin
        if (goodSum <= GOOD_L) goodCnt <= goodSum[GOOD_W-1:0];
        if (goodSum >= GOOD_L) lockReg <= 1'b1;
      end
    end else if (st.busy) begin
      if (overWin) begin
        errCnt  <= WIN_S;
        goodCnt <= '0;
        lockReg <= 1'b0;
      end else begin
        errCnt <= errSum[CNT_W-1:0];
      end
    end else begin
      errCnt <= '0;
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter int WINDOW    = 12,
  parameter int GOOD_RUNS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerOn,
  input  logic polarity,
  input  logic refIn,
  input  logic divIn,
  output logic driveUp,
  output logic driveDown,
  output logic locked,
  output logic alignReq
);
  cmpStrobe_t ctrlSt;
  logic leadRef, leadDiv, lockReg, cmpDone;

  pfd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerOn  (powerOn),
    .refIn    (refIn),
    .divIn    (divIn),
    .leadRef  (leadRef),
    .leadDiv  (leadDiv),
    .alignReq (alignReq),
    .st       (ctrlSt)
  );

  pfd_datapath #(.WINDOW(WINDOW), .GOOD_RUNS(GOOD_RUNS)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .st      (ctrlSt),
    .lockReg (lockReg)
  );

  assign cmpDone   = ctrlSt.done;
  assign driveUp   = powerOn & (polarity ? leadRef : leadDiv);
  assign driveDown = powerOn & (polarity ? leadDiv : leadRef);
  assign locked    = ~powerOn | lockReg;
endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker (
  input logic clk,
  input logic rstN,
  input logic powerOn,
  input logic driveUp,
  input logic driveDown,
  input logic locked,
  input logic alignReq,
  input logic cmpDone
);
  a_r5_no_conflict: assert property (@(posedge clk) disable iff (!rstN)
    !(driveUp && driveDown));

  a_r10_standby_parked: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |-> (!driveUp && !driveDown && locked));

  a_r7_lock_on_close: assert property (@(posedge clk) disable iff (!rstN)
    (powerOn && $past(powerOn) && $rose(locked)) |-> $past(cmpDone));

  a_r11_align_after_wake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerOn) |=> alignReq);

  a_r11_align_single: assert property (@(posedge clk) disable iff (!rstN)
    alignReq |=> !alignReq);
endmodule

bind pfd_lock_top pfd_lock_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .powerOn   (powerOn),
  .driveUp   (driveUp),
  .driveDown (driveDown),
  .locked    (locked),
  .alignReq  (alignReq),
  .cmpDone   (cmpDone)
);

// File: tb/test_pfd_lock_top.sv
`timescale 1ns/1ps
module test_pfd_lock_top;
  localparam int WIN = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerOn = 1'b0, polarity = 1'b1, refIn = 1'b0, divIn = 1'b0;
  logic driveUp, driveDown, locked, alignReq;

  int checks = 0, fails = 0;
  int goodRun = 0;
  bit expLock = 1'b0;
  bit finished = 1'b0;
  logic sUp, sDn, sLk, sAl;
  bit bothSeen;

  always #4 clk = ~clk;

  pfd_lock_top i_pfd_lock_top (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .polarity(polarity),
    .refIn(refIn), .divIn(divIn), .driveUp(driveUp), .driveDown(driveDown),
    .locked(locked), .alignReq(alignReq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sample outputs at the falling edge, then drive the next inputs
  task automatic tick(input logic r, input logic d, input logic pw);
    @(negedge clk);
    sUp = driveUp; sDn = driveDown; sLk = locked; sAl = alignReq;
    if (sUp && sDn) bothSeen = 1'b1;
    refIn = r; divIn = d; powerOn = pw;
  endtask

  function automatic bit nextLock(input int gap);
    return (gap < WIN) && (goodRun + 1 >= 3);
  endfunction

  task automatic compare(input bit refFirst, input int gap, input bit polHi);
    int upCnt = 0, dnCnt = 0;
    bit prevLk = expLock;
    bit newLk = nextLock(gap);
    string tag;
    polarity = polHi;
    bothSeen = 1'b0;
    for (int i = 0; i <= gap + 3; i++) begin
      tick(refFirst ? (i == 0) : (i == gap), refFirst ? (i == gap) : (i == 0), 1'b1);
      if (i >= 1) begin
        upCnt += int'(sUp);
        dnCnt += int'(sDn);
      end
      if (gap >= WIN && i == WIN) check(sLk == prevLk, "R8 lock held before window", sLk, prevLk);
      if (gap >= WIN && i == WIN + 1) check(sLk == 1'b0, "R8 early unlock", sLk, 0);
      if (i == gap + 1) check(sLk == newLk, gap >= WIN ? "R9 bad compare" : "R7 lock timing", sLk, newLk);
    end
    if (gap == 0) tag = "R4";
    else if (!polHi) tag = "R3";
    else tag = refFirst ? "R1" : "R2";
    check(upCnt == (((refFirst == polHi) && gap > 0) ? gap : 0), {tag, " up width"}, upCnt,
          ((refFirst == polHi) && gap > 0) ? gap : 0);
    check(dnCnt == (((refFirst != polHi) && gap > 0) ? gap : 0), {tag, " down width"}, dnCnt,
          ((refFirst != polHi) && gap > 0) ? gap : 0);
    check(!bothSeen, "R5 both drives", int'(bothSeen), 0);
    if (gap >= WIN) goodRun = 0; else goodRun = (goodRun < 3) ? goodRun + 1 : 3;
    expLock = newLk || (gap < WIN && expLock);
    tick(1'b0, 1'b0, 1'b1);
    check(sLk == expLock, "R7 lock after compare", sLk, expLock);
  endtask

  initial begin
    int seedInit;
    int upCnt;
    seedInit = $urandom(32'd1503);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(1'b0, 1'b0, 1'b0);
    check(!sUp && !sDn, "R12 drives after reset", int'(sUp) + int'(sDn), 0);
    check(sLk == 1'b1, "R12 standby reads locked", sLk, 1);
    check(sAl == 1'b0, "R12 align idle", sAl, 0);
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    check(sAl == 1'b1 && sLk == 1'b0, "R12 R11 wake from reset", {sAl, sLk}, 2);
    tick(1'b0, 1'b0, 1'b1);
    check(sAl == 1'b0, "R11 align single cycle", sAl, 0);

    // directed corners
    compare(1'b1, 0, 1'b1);
    compare(1'b1, 1, 1'b1);
    compare(1'b0, 5, 1'b1);
    compare(1'b1, 11, 1'b1);
    compare(1'b0, 3, 1'b0);
    compare(1'b1, 12, 1'b1);
    compare(1'b1, 16, 1'b0);
    compare(1'b1, 4, 1'b1);
    compare(1'b0, 2, 1'b1);

    // R6: repeated reference edge while pending
    polarity = 1'b1; upCnt = 0; bothSeen = 1'b0;
    for (int i = 0; i <= 8; i++) begin
      tick((i == 0) || (i == 3), i == 5, 1'b1);
      if (i >= 1) upCnt += int'(sUp);
    end
    check(upCnt == 5, "R6 pulse continues", upCnt, 5);
    goodRun = (goodRun < 3) ? goodRun + 1 : 3;
    expLock = goodRun >= 3;
    check(sLk == expLock, "R6 lock after repeat", sLk, expLock);

    // random comparisons
    for (int n = 0; n < 40; n++)
      compare(1'($urandom_range(0, 1)), $urandom_range(0, 15), 1'($urandom_range(0, 1)));

    // standby with a pending pulse (R10, R11)
    compare(1'b1, 14, 1'b1);
    polarity = 1'b1;
    tick(1'b1, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    check(sUp == 1'b1, "R1 pending before standby", sUp, 1);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    check(!sUp && !sDn && sLk, "R10 parked", {sUp, sDn, sLk}, 1);
    tick(1'b0, 1'b0, 1'b0);
    check(!sUp && !sDn && sLk, "R10 edge ignored", {sUp, sDn, sLk}, 1);
    tick(1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    check(!sUp && !sDn, "R10 edge in standby", int'(sUp) + int'(sDn), 0);
    tick(1'b0, 1'b0, 1'b1);
    check(sAl == 1'b1, "R11 align pulse", sAl, 1);
    check(!sUp && !sDn && !sLk, "R11 cleared after wake", {sUp, sDn, sLk}, 0);
    tick(1'b0, 1'b0, 1'b1);
    check(sAl == 1'b0, "R11 align ends", sAl, 0);
    goodRun = 0; expLock = 1'b0;
    compare(1'b1, 2, 1'b1);
    compare(1'b0, 6, 1'b1);
    compare(1'b1, 9, 1'b0);
    check(sLk == 1'b1, "R11 relock after three", sLk, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule